// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block takes read requests one at a time and turns each into the command sequence a single DRAM bank needs. It remembers whether the bank has an open row and which row that is. A request to the open row is a hit and gets a column read only. A request to a different row is a conflict: the open row is precharged, the new row is activated, and then the column read follows. A request to a bank with no open row gets an activate and then the read. The block holds each command back until its timing gap has passed: tRP after a precharge, tRCD after an activate, and CL from the read to the first data beat. It then counts the eight beats of the burst.

A run-time policy input chooses what happens after the last beat. In open-page mode the row is left open, so the next request to that row can be a hit. In closed-page mode the row is precharged at once, so requests that follow start from an empty bank and all have the same latency. The policy is sampled when a request is accepted. Each finished request raises a one-cycle completion strobe, together with a flag that says whether the request was a hit, for performance counting.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd` is NOP, `beat_valid` and `done` are 0, and the bank holds no open row. The first request after any reset therefore takes the empty-bank path, even if a row was open before the reset.
- R2: Hit (the requested row is open): the only command is READ, in the cycle after acceptance. The first beat comes TCL cycles after the READ.
- R3: Conflict (a different row is open): PRECHARGE comes in the cycle after acceptance, ACTIVATE comes TRP cycles later, READ comes TRCD cycles after ACTIVATE, and the first beat comes TCL cycles after READ.
- R4: Empty bank: ACTIVATE comes in the cycle after acceptance, with no PRECHARGE. READ comes TRCD cycles later and the first beat TCL cycles after that.
- R5: Each READ yields exactly 8 beats in consecutive cycles, with `beat_idx` running 0 to 7. `done` pulses in the cycle after the last beat.
- R6: In open-page mode (`page_closed`=0) the row stays open after `done`, so a later request to the same row is a hit. `req_ready` returns in the `done` cycle.
- R7: In closed-page mode (`page_closed`=1) PRECHARGE is issued in the `done` cycle and `req_ready` returns TRP cycles later. The next request then takes the empty-bank path.
- R8: `req_ready` is 0 from acceptance until the sequence ends. `req_valid` and the request fields have no effect while `req_ready` is 0.
- R9: `done_hit` is 1 together with `done` for a hit and 0 for a conflict or empty-bank access.
- R10: The `cmd` encoding is NOP=0, ACTIVATE=1, READ=2, PRECHARGE=3. `cmd_row` carries the accepted row during ACTIVATE. `cmd_col` carries the accepted column during READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_closed | input | 1 | 1 selects closed-page mode, 0 selects open-page mode; sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept a request |
| req_bank | input | BANK_W | Bank address, passed through with the commands |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address |
| cmd | output | 2 | Command to the bank (R10 encoding) |
| cmd_bank | output | BANK_W | Bank address of the current request |
| cmd_row | output | ROW_W | Row address of the current request |
| cmd_col | output | COL_W | Column address of the current request |
| beat_valid | output | 1 | A data beat is due in this cycle |
| beat_idx | output | clog2(BURST) | Index of the beat within the burst |
| done | output | 1 | One-cycle strobe when a request completes |
| done_hit | output | 1 | The completed request was a row hit |

## Verification
Every result is timed from the acceptance edge. The first command appears in the following cycle. The later commands follow at offsets of TRP and TRCD. The first beat comes TCL after READ, `done` comes eight cycles after the first beat, and `req_ready` returns either in the `done` cycle or TRP later. The bench uses distinct values for TRP, TRCD and TCL, so that an offset attached to the wrong gap shows up as a wrong cycle number. It records the cycle number of every command, beat and ready edge at the falling clock edge and compares each against the offsets computed for the path that the vector names.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_ACT = 2'd1,
        CMD_RD  = 2'd2,
        CMD_PRE = 2'd3
    } dcmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_CL,
        S_BURST,
        S_CLOSE
    } dstate_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dseq_timer.sv
module dseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dseq_row_track.sv
module dseq_row_track #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] load_row,
    input  logic [ROW_W-1:0] cmp_row,
    output logic             is_open,
    output logic             row_hit
);
    logic [ROW_W-1:0] row_q;
    logic             open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            row_q  <= '0;
        end else if (open_en) begin
            open_q <= 1'b1;
            row_q  <= load_row;
        end else if (close_en) begin
            open_q <= 1'b0;
        end
    end

    assign is_open = open_q;
    assign row_hit = open_q && (row_q == cmp_row);

    // an activate only ever targets a precharged bank (R4)
    p_act_on_closed_r4: assert property (@(posedge clk) disable iff (rst)
        open_en |-> !open_q);
    // a precharge only ever closes an open row (R3)
    p_pre_on_open_r3: assert property (@(posedge clk) disable iff (rst)
        close_en |-> open_q);
endmodule

// File: rtl/dseq_beat_ctr.sv
module dseq_beat_ctr #(
    parameter int BURST = 8,
    localparam int IW = $clog2(BURST)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          valid,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] LAST_IDX = IW'(BURST - 1);

    logic          valid_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else if (start) begin
            valid_q <= 1'b1;
            idx_q   <= '0;
        end else if (valid_q) begin
            if (idx_q == LAST_IDX) begin
                valid_q <= 1'b0;
                idx_q   <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign valid = valid_q;
    assign idx   = idx_q;
    assign last  = valid_q && (idx_q == LAST_IDX);

    // beats run back to back with a rising index (R5)
    p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_q && idx_q != LAST_IDX) |=> (valid_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dseq_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int BANK_W = 3,
    parameter int TRP    = 2,
    parameter int TRCD   = 3,
    parameter int TCL    = 4,
    parameter int BURST  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      page_closed,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ROW_W-1:0]          req_row,
    input  logic [COL_W-1:0]          req_col,
    output logic [1:0]                cmd,
    output logic [BANK_W-1:0]         cmd_bank,
    output logic [ROW_W-1:0]          cmd_row,
    output logic [COL_W-1:0]          cmd_col,
    output logic                      beat_valid,
    output logic [$clog2(BURST)-1:0]  beat_idx,
    output logic                      done,
    output logic                      done_hit
);
    localparam int TMAX = max3(TRP, TRCD, TCL);
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] LD_RP  = TW'(TRP - 1);
    localparam logic [TW-1:0] LD_RCD = TW'(TRCD - 1);
    localparam logic [TW-1:0] LD_CL  = TW'(TCL - 1);

    initial begin
        if (TRP < 1 || TRCD < 1 || TCL < 1)
            $error("timing parameters must be at least one cycle");
    end

    dstate_e           state_q, state_n;
    dcmd_e             cmd_q, cmd_n;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [BANK_W-1:0] bank_q;
    logic              pol_q, hit_q, done_q, dhit_q;

    logic          accept, fin;
    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          open_en, close_en, trk_open, trk_hit;
    logic          b_start, b_last;
    logic [ROW_W-1:0] trk_row;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign trk_row   = (state_q == S_IDLE) ? req_row : row_q;

    dseq_timer #(.W(TW)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_zero)
    );

    dseq_row_track #(.ROW_W(ROW_W)) u_track (
        .clk(clk), .rst(rst), .open_en(open_en), .close_en(close_en),
        .load_row(trk_row), .cmp_row(req_row), .is_open(trk_open), .row_hit(trk_hit)
    );

    dseq_beat_ctr #(.BURST(BURST)) u_beats (
        .clk(clk), .rst(rst), .start(b_start), .valid(beat_valid), .idx(beat_idx), .last(b_last)
    );

    always_comb begin
        state_n  = state_q;
        cmd_n    = CMD_NOP;
        t_load   = 1'b0;
        t_val    = '0;
        open_en  = 1'b0;
        close_en = 1'b0;
        b_start  = 1'b0;
        fin      = 1'b0;
        unique case (state_q)
            S_IDLE: if (accept) begin
                t_load = 1'b1;
                if (trk_hit) begin
                    cmd_n = CMD_RD;  t_val = LD_CL;  state_n = S_CL;
                end else if (trk_open) begin
                    cmd_n = CMD_PRE; t_val = LD_RP;  state_n = S_PRE; close_en = 1'b1;
                end else begin
                    cmd_n = CMD_ACT; t_val = LD_RCD; state_n = S_ACT; open_en = 1'b1;
                end
            end
            S_PRE: if (t_zero) begin
                cmd_n = CMD_ACT; t_load = 1'b1; t_val = LD_RCD; state_n = S_ACT; open_en = 1'b1;
            end
            S_ACT: if (t_zero) begin
                cmd_n = CMD_RD; t_load = 1'b1; t_val = LD_CL; state_n = S_CL;
            end
            S_CL: if (t_zero) begin
                b_start = 1'b1; state_n = S_BURST;
            end
            S_BURST: if (b_last) begin
                fin = 1'b1;
                if (pol_q) begin
                    cmd_n = CMD_PRE; t_load = 1'b1; t_val = LD_RP; state_n = S_CLOSE; close_en = 1'b1;
                end else begin
                    state_n = S_IDLE;
                end
            end
            S_CLOSE: if (t_zero) state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cmd_q   <= CMD_NOP;
            row_q   <= '0;
            col_q   <= '0;
            bank_q  <= '0;
            pol_q   <= 1'b0;
            hit_q   <= 1'b0;
            done_q  <= 1'b0;
            dhit_q  <= 1'b0;
        end else begin
            state_q <= state_n;
            cmd_q   <= cmd_n;
            done_q  <= fin;
            dhit_q  <= fin && hit_q;
            if (accept) begin
                row_q  <= req_row;
                col_q  <= req_col;
                bank_q <= req_bank;
                pol_q  <= page_closed;
                hit_q  <= trk_hit;
            end
        end
    end

    assign cmd      = cmd_q;
    assign cmd_row  = row_q;
    assign cmd_col  = col_q;
    assign cmd_bank = bank_q;
    assign done     = done_q;
    assign done_hit = dhit_q;

    p_hit_read_r2: assert property (@(posedge clk) disable iff (rst)
        (accept && trk_hit) |=> (cmd == CMD_RD));
    p_conflict_pre_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && trk_open && !trk_hit) |=> (cmd == CMD_PRE));
    p_empty_act_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && !trk_open) |=> (cmd == CMD_ACT));
    p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
        b_last |=> done);
    p_closed_pre_r7: assert property (@(posedge clk) disable iff (rst)
        (done && pol_q) |-> (cmd == CMD_PRE));
    p_busy_in_burst_r8: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> !req_ready);
    p_hit_flag_r9: assert property (@(posedge clk) disable iff (rst)
        done_hit |-> done);
endmodule

// File: tb/sim_dram_bank_seq.sv
module sim_dram_bank_seq;
    localparam int TRP = 3, TRCD = 4, TCL = 5;
    localparam int HIT = 0, CONF = 1, EMPTY = 2;

    typedef struct packed {
        logic        cl;
        logic [13:0] row;
        logic [9:0]  col;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VECS [11] = '{
        '{1'b0, 14'd5, 10'd17,  2'd2},
        '{1'b0, 14'd5, 10'd18,  2'd0},
        '{1'b0, 14'd5, 10'd900, 2'd0},
        '{1'b0, 14'd9, 10'd3,   2'd1},
        '{1'b0, 14'd9, 10'd4,   2'd0},
        '{1'b1, 14'd9, 10'd5,   2'd0},
        '{1'b1, 14'd9, 10'd6,   2'd2},
        '{1'b1, 14'd2, 10'd7,   2'd2},
        '{1'b0, 14'd2, 10'd8,   2'd2},
        '{1'b0, 14'd2, 10'd9,   2'd0},
        '{1'b0, 14'd3, 10'd10,  2'd1}
    };

    logic clk = 0, rst = 1, page_closed = 0, req_valid = 0;
    logic req_ready, beat_valid, done, done_hit;
    logic [2:0] req_bank = 0, cmd_bank;
    logic [13:0] req_row = 0, cmd_row;
    logic [9:0] req_col = 0, cmd_col;
    logic [1:0] cmd;
    logic [2:0] beat_idx;

    dram_bank_seq #(.ROW_W(14), .COL_W(10), .BANK_W(3), .TRP(TRP), .TRCD(TRCD), .TCL(TCL), .BURST(8)) u0 (
        .clk(clk), .rst(rst), .page_closed(page_closed), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .cmd(cmd), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .beat_valid(beat_valid), .beat_idx(beat_idx),
        .done(done), .done_hit(done_hit)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, errors = 0;
    int n_cmd, n_beat, first_t, done_t, done_h, rdy_t, beat_bad;
    int lk [8], lt [8], lr [8], lc [8];

    always @(negedge clk) if (!rst) begin
        if (cmd != 2'd0 && n_cmd < 8) begin
            lk[n_cmd] = cmd; lt[n_cmd] = cyc; lr[n_cmd] = cmd_row; lc[n_cmd] = cmd_col;
            n_cmd++;
        end
        if (beat_valid) begin
            if (n_beat == 0) first_t = cyc;
            if (beat_idx != 3'(n_beat)) beat_bad = 1;
            n_beat++;
        end
        if (done) begin done_t = cyc; done_h = done_hit; end
        if (done_t >= 0 && req_ready && rdy_t < 0) rdy_t = cyc;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        n_cmd = 0; n_beat = 0; first_t = -1; done_t = -1; done_h = -1; rdy_t = -1; beat_bad = 0;
    endtask

    task automatic run(input bit cl, input int row, input int col, input int kind, input bit hold);
        int acc, rd, ek [8], et [8], ne, fb, dn;
        @(negedge clk);
        clear_log();
        page_closed = cl; req_row = 14'(row); req_col = 10'(col); req_bank = 3'(row);
        req_valid = 1;
        @(posedge clk); #1;
        acc = cyc;
        if (hold) begin
            req_row = 14'(row + 100); req_col = 10'(col + 1); page_closed = ~cl;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(req_ready == 0, "R8", "ready while busy", req_ready, 0);
            end
        end
        req_valid = 0;
        ne = 0;
        if (kind == CONF) begin ek[0] = 3; et[0] = acc; ek[1] = 1; et[1] = acc + TRP; rd = acc + TRP + TRCD; ne = 2; end
        else if (kind == EMPTY) begin ek[0] = 1; et[0] = acc; rd = acc + TRCD; ne = 1; end
        else rd = acc;
        ek[ne] = 2; et[ne] = rd; ne++;
        fb = rd + TCL; dn = fb + 8;
        if (cl) begin ek[ne] = 3; et[ne] = dn; ne++; end
        while (rdy_t < 0) @(negedge clk);
        @(negedge clk);
        chk(n_cmd == ne, kind == HIT ? "R2" : kind == CONF ? "R3" : "R4", "command count", n_cmd, ne);
        for (int i = 0; i < ne && i < n_cmd; i++) begin
            chk(lk[i] == ek[i], "R10", "command code", lk[i], ek[i]);
            chk(lt[i] == et[i], kind == HIT ? "R2" : kind == CONF ? "R3" : "R4", "command cycle", lt[i] - acc, et[i] - acc);
            if (lk[i] == 1) chk(lr[i] == row, "R10", "activate row", lr[i], row);
            if (lk[i] == 2) chk(lc[i] == col, "R10", "read column", lc[i], col);
        end
        chk(first_t == fb, "R2", "first beat offset", first_t - acc, fb - acc);
        chk(n_beat == 8 && beat_bad == 0, "R5", "beat count", n_beat, 8);
        chk(done_t == dn, "R5", "done cycle", done_t - acc, dn - acc);
        chk(done_h == (kind == HIT), "R9", "hit flag", done_h, kind == HIT);
        if (cl) chk(rdy_t == dn + TRP, "R7", "ready return", rdy_t - dn, TRP);
        else    chk(rdy_t == dn, "R6", "ready return", rdy_t - dn, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_log();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        chk(cmd == 0, "R1", "cmd after reset", cmd, 0);
        chk(beat_valid == 0 && done == 0, "R1", "beat/done after reset", beat_valid, 0);
        foreach (VECS[i]) run(VECS[i].cl, int'(VECS[i].row), int'(VECS[i].col), int'(VECS[i].kind), 0);
        // R1: reset during a conflict sequence forgets the open row
        @(negedge clk);
        req_valid = 1; req_row = 14'd4; page_closed = 0;
        @(negedge clk);
        req_valid = 0;
        repeat (2) @(negedge clk);
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        chk(req_ready == 1 && cmd == 0, "R1", "ready after mid reset", req_ready, 1);
        run(0, 3, 11, EMPTY, 0);
        // R8: request fields changed while busy have no effect
        run(0, 3, 12, HIT, 1);
        run(0, 3, 13, HIT, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule